// File: doc/BRIEF.md
# Power Gating Sequencer

This controller lives in the always-on part of a chip that has two switchable supply regions: a low-voltage region whose supply can be cut, and a high-voltage region nested inside the always-on area. A requester asks for one of four power states. The controller then steps the power-switch enables, the isolation controls and the retention line of the two regions in a safe order. It waits for each switch acknowledge and for programmable settle counts. It reports the present state, a busy flag and a refusal pulse.

The controller also contains the isolation clamps for the three signals that leave the switchable regions. Each clamp holds a fixed value while its region is isolated. The low-voltage region has one retained register, and the single retention line saves it when driven high and restores it when driven low. A change of state that touches both regions is carried out one region at a time. The high-voltage region is never switched off while the low-voltage region's switch is closed.

Top module: `pwr_gate_seq`

## Requirements
- R1: After reset `cur_state` is 0, both switch enables are 1, both isolation controls are 0, `ret_save` is 0 and `busy` is 0.
- R2: State codes on `req_state` and `cur_state` are bit 0 = high-voltage region on and bit 1 = low-voltage region on: 0 both off, 1 high-voltage only, 2 low-voltage only, 3 both on. A request with bit 2 set (codes 4 to 7) pulses `req_err` for one cycle and changes nothing.
- R3: A region is powered while its switch enable is 0. On power-up the region's isolation is released only after its acknowledge input has been seen high. For the low-voltage region, isolation rises exactly `settle_cycles + restore_cycles + 2` cycles after that acknowledge is first sampled high.
- R4: While a region's isolation control is 0, `lo_out_a_iso` is 1, `lo_out_b_iso` is 0 and `hi_out_iso` is 1 for the isolated region's outputs. Otherwise each output follows its input.
- R5: Low-voltage power-down: isolation goes to 0. One cycle later `ret_save` goes to 1. `save_cycles + 1` cycles after that, the switch enable goes to 1. The state changes once the acknowledge has fallen.
- R6: Low-voltage power-up: the switch enable goes to 0. After the acknowledge has been seen plus `settle_cycles + 1` cycles, `ret_save` goes to 0. `restore_cycles + 1` cycles later, isolation goes to 1.
- R7: Steps on the high-voltage region never change `ret_save`.
- R8: A request that would switch off the high-voltage region while the low-voltage region stays on (code 2 requested from state 3) is refused with a `req_err` pulse, and the state is kept.
- R9: A change of both regions is split into steps. Low-voltage power-down comes before high-voltage power-down, low-voltage power-up comes before high-voltage power-up, and a power-down comes before a power-up. The high-voltage switch enable never rises while the low-voltage switch enable is 0.
- R10: While `busy` is 1, `req_valid` is ignored.
- R11: A request equal to `cur_state` is a no-op: `busy` stays 0 and `req_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | One-cycle request strobe |
| req_state | input | 3 | Requested state code |
| save_cycles | input | CNT_W | Wait after the retention save before the switch opens |
| settle_cycles | input | CNT_W | Wait after the switch acknowledge on power-up |
| restore_cycles | input | CNT_W | Wait after the restore before isolation is released |
| lo_ack | input | 1 | Low-voltage switch acknowledge, high when the supply is connected |
| hi_ack | input | 1 | High-voltage switch acknowledge, high when the supply is connected |
| lo_out_a | input | 1 | Low-voltage region output A, raw |
| lo_out_b | input | 1 | Low-voltage region output B, raw |
| hi_out | input | 1 | High-voltage region output, raw |
| lo_sw_en | output | 1 | Low-voltage switch enable, 1 = supply cut |
| hi_sw_en | output | 1 | High-voltage switch enable, 1 = supply cut |
| lo_iso_n | output | 1 | Low-voltage isolation, active low |
| hi_iso_n | output | 1 | High-voltage isolation, active low |
| ret_save | output | 1 | Retention line, 1 = save, falling edge = restore |
| lo_out_a_iso | output | 1 | Output A after its clamp (clamps to 1) |
| lo_out_b_iso | output | 1 | Output B after its clamp (clamps to 0) |
| hi_out_iso | output | 1 | High-voltage output after its clamp (clamps to 1) |
| cur_state | output | 3 | Present state code |
| busy | output | 1 | A sequence is in progress |
| req_err | output | 1 | One-cycle pulse for an illegal or refused request |

## Verification
The assertions take for granted that each acknowledge follows its switch enable. An acknowledge rises only some cycles after its enable goes low, falls only after the enable goes high, and never moves on its own. Without that, the check that isolation is released only under a high acknowledge would have no meaning. The bench models both acknowledges as a three-stage delay of the inverted switch enables. It holds the count inputs constant for the whole run and drives requests as single-cycle strobes away from the clock edge.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int REQ_W = 3;

  localparam logic [REQ_W-1:0] ST_ALL_OFF = 3'd0;
  localparam logic [REQ_W-1:0] ST_HI_ONLY = 3'd1;
  localparam logic [REQ_W-1:0] ST_LO_ONLY = 3'd2;
  localparam logic [REQ_W-1:0] ST_BOTH_ON = 3'd3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ISO,
    PH_SAVE,
    PH_SW_OFF,
    PH_SW_ON,
    PH_SETTLE,
    PH_RESTORE
  } dom_phase_e;

  typedef enum logic [1:0] {
    CT_IDLE,
    CT_PICK,
    CT_WAIT
  } ctrl_state_e;

endpackage

// File: rtl/pwr_iso_clamp.sv
module pwr_iso_clamp #(
  parameter logic CLAMP = 1'b0
) (
  input  logic iso_n,
  input  logic d,
  output logic q
);

  always_comb begin
    if (iso_n) q = d;
    else       q = CLAMP;
  end

endmodule

// File: rtl/pwr_dom_step.sv
module pwr_dom_step
  import pwr_seq_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter bit HAS_RET = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_dn,
  input  logic             go_up,
  input  logic             ack,
  input  logic [CNT_W-1:0] save_cyc,
  input  logic [CNT_W-1:0] settle_cyc,
  input  logic [CNT_W-1:0] restore_cyc,
  output logic             sw_en,
  output logic             iso_n,
  output logic             ret,
  output logic             is_on,
  output logic             done
);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  dom_phase_e       ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sw_q, sw_d;
  logic             iso_q, iso_d;
  logic             ret_q, ret_d;
  logic             on_q, on_d;
  logic             done_q, done_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == CNT_ZERO);

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    sw_d   = sw_q;
    iso_d  = iso_q;
    ret_d  = ret_q;
    on_d   = on_q;
    done_d = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (go_dn && on_q) begin
          iso_d = 1'b0;
          ph_d  = PH_ISO;
        end else if (go_up && !on_q) begin
          sw_d = 1'b0;
          ph_d = PH_SW_ON;
        end
      end
      PH_ISO: begin
        if (HAS_RET) begin
          ret_d = 1'b1;
          cnt_d = save_cyc;
          ph_d  = PH_SAVE;
        end else begin
          sw_d = 1'b1;
          ph_d = PH_SW_OFF;
        end
      end
      PH_SAVE: begin
        if (cnt_zero) begin
          sw_d = 1'b1;
          ph_d = PH_SW_OFF;
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
      PH_SW_OFF: begin
        if (!ack) begin
          on_d   = 1'b0;
          done_d = 1'b1;
          ph_d   = PH_IDLE;
        end
      end
      PH_SW_ON: begin
        if (ack) begin
          cnt_d = settle_cyc;
          ph_d  = PH_SETTLE;
        end
      end
      PH_SETTLE: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - CNT_ONE;
        end else if (HAS_RET) begin
          ret_d = 1'b0;
          cnt_d = restore_cyc;
          ph_d  = PH_RESTORE;
        end else begin
          iso_d  = 1'b1;
          on_d   = 1'b1;
          done_d = 1'b1;
          ph_d   = PH_IDLE;
        end
      end
      PH_RESTORE: begin
        if (cnt_zero) begin
          iso_d  = 1'b1;
          on_d   = 1'b1;
          done_d = 1'b1;
          ph_d   = PH_IDLE;
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      sw_q   <= 1'b1;
      iso_q  <= 1'b0;
      ret_q  <= 1'b0;
      on_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      sw_q   <= sw_d;
      iso_q  <= iso_d;
      ret_q  <= ret_d;
      on_q   <= on_d;
      done_q <= done_d;
    end
  end

  assign sw_en = sw_q;
  assign iso_n = iso_q;
  assign ret   = ret_q;
  assign is_on = on_q;
  assign done  = done_q;

  AST_CUT_NEEDS_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    sw_q |-> !iso_q); // R3
  AST_SAVE_UNDER_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    ret_q |-> !iso_q); // R5
  AST_RELEASE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iso_q) |-> ack); // R3

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [REQ_W-1:0] req_state,
  input  logic             lo_on,
  input  logic             hi_on,
  input  logic             lo_done,
  input  logic             hi_done,
  output logic             go_lo_dn,
  output logic             go_lo_up,
  output logic             go_hi_dn,
  output logic             go_hi_up,
  output logic             busy,
  output logic             req_err
);

  ctrl_state_e st_q, st_d;
  logic [1:0]  tgt_q, tgt_d;
  logic [3:0]  go_q, go_d;
  logic        err_q, err_d;
  logic [1:0]  cur;
  logic        nest_break;

  assign cur = {lo_on, hi_on};
  // would switch the high-voltage region off while the low one stays on
  assign nest_break = lo_on && req_state[1] && hi_on && !req_state[0];

  always_comb begin
    st_d  = st_q;
    tgt_d = tgt_q;
    go_d  = 4'b0000;
    err_d = 1'b0;
    unique case (st_q)
      CT_IDLE: begin
        if (req_valid) begin
          if (req_state[REQ_W-1]) begin
            err_d = 1'b1;
          end else if (req_state[1:0] == cur) begin
            st_d = CT_IDLE;
          end else if (nest_break) begin
            err_d = 1'b1;
          end else begin
            tgt_d = req_state[1:0];
            st_d  = CT_PICK;
          end
        end
      end
      CT_PICK: begin
        st_d = CT_WAIT;
        if (lo_on && !tgt_q[1])       go_d = 4'b0001;
        else if (hi_on && !tgt_q[0])  go_d = 4'b0100;
        else if (!lo_on && tgt_q[1])  go_d = 4'b0010;
        else if (!hi_on && tgt_q[0])  go_d = 4'b1000;
        else                          st_d = CT_IDLE;
      end
      CT_WAIT: begin
        if (lo_done || hi_done) st_d = CT_PICK;
      end
      default: st_d = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CT_IDLE;
      tgt_q <= 2'b00;
      go_q  <= 4'b0000;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      tgt_q <= tgt_d;
      go_q  <= go_d;
      err_q <= err_d;
    end
  end

  assign go_lo_dn = go_q[0];
  assign go_lo_up = go_q[1];
  assign go_hi_dn = go_q[2];
  assign go_hi_up = go_q[3];
  assign busy     = (st_q != CT_IDLE);
  assign req_err  = err_q;

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> (tgt_q == $past(tgt_q))); // R10
  AST_ERR_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !busy); // R2
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_lo_dn, go_lo_up, go_hi_dn, go_hi_up})); // R9

endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq
  import pwr_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_state,
  input  logic [CNT_W-1:0] save_cycles,
  input  logic [CNT_W-1:0] settle_cycles,
  input  logic [CNT_W-1:0] restore_cycles,
  input  logic             lo_ack,
  input  logic             hi_ack,
  input  logic             lo_out_a,
  input  logic             lo_out_b,
  input  logic             hi_out,
  output logic             lo_sw_en,
  output logic             hi_sw_en,
  output logic             lo_iso_n,
  output logic             hi_iso_n,
  output logic             ret_save,
  output logic             lo_out_a_iso,
  output logic             lo_out_b_iso,
  output logic             hi_out_iso,
  output logic [2:0]       cur_state,
  output logic             busy,
  output logic             req_err
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       go_lo_dn, go_lo_up, go_hi_dn, go_hi_up;
  logic       lo_on, hi_on, lo_done, hi_done;
  logic       hi_ret;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pwr_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_state (req_state),
    .lo_on     (lo_on),
    .hi_on     (hi_on),
    .lo_done   (lo_done),
    .hi_done   (hi_done),
    .go_lo_dn  (go_lo_dn),
    .go_lo_up  (go_lo_up),
    .go_hi_dn  (go_hi_dn),
    .go_hi_up  (go_hi_up),
    .busy      (busy),
    .req_err   (req_err)
  );

  pwr_dom_step #(.CNT_W(CNT_W), .HAS_RET(1'b1)) u_lo (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .go_dn       (go_lo_dn),
    .go_up       (go_lo_up),
    .ack         (lo_ack),
    .save_cyc    (save_cycles),
    .settle_cyc  (settle_cycles),
    .restore_cyc (restore_cycles),
    .sw_en       (lo_sw_en),
    .iso_n       (lo_iso_n),
    .ret         (ret_save),
    .is_on       (lo_on),
    .done        (lo_done)
  );

  pwr_dom_step #(.CNT_W(CNT_W), .HAS_RET(1'b0)) u_hi (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .go_dn       (go_hi_dn),
    .go_up       (go_hi_up),
    .ack         (hi_ack),
    .save_cyc    (save_cycles),
    .settle_cyc  (settle_cycles),
    .restore_cyc (restore_cycles),
    .sw_en       (hi_sw_en),
    .iso_n       (hi_iso_n),
    .ret         (hi_ret),
    .is_on       (hi_on),
    .done        (hi_done)
  );

  pwr_iso_clamp #(.CLAMP(1'b1)) u_clamp_a (.iso_n(lo_iso_n), .d(lo_out_a), .q(lo_out_a_iso));
  pwr_iso_clamp #(.CLAMP(1'b0)) u_clamp_b (.iso_n(lo_iso_n), .d(lo_out_b), .q(lo_out_b_iso));
  pwr_iso_clamp #(.CLAMP(1'b1)) u_clamp_h (.iso_n(hi_iso_n), .d(hi_out),   .q(hi_out_iso));

  assign cur_state = {1'b0, lo_on, hi_on};

  AST_NEST_ORDER: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(hi_sw_en) |-> lo_sw_en); // R9
  AST_LO_CLAMPED_OFF: assert property (@(posedge clk) disable iff (!rst_int_n)
    lo_sw_en |-> (lo_out_a_iso && !lo_out_b_iso)); // R4
  AST_HI_CLAMPED_OFF: assert property (@(posedge clk) disable iff (!rst_int_n)
    hi_sw_en |-> hi_out_iso); // R4
  AST_HI_NO_RET: assert property (@(posedge clk) disable iff (!rst_int_n)
    !hi_ret); // R7

endmodule

// File: tb/sim_pwr_gate_seq.sv
`timescale 1ns/1ps
module sim_pwr_gate_seq;

  localparam int CW      = 8;
  localparam int SAVE    = 2;
  localparam int SETTLE  = 3;
  localparam int RESTORE = 4;
  localparam int ACK_LAT = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [2:0] req_state;
  logic lo_ack, hi_ack;
  logic lo_out_a, lo_out_b, hi_out;
  logic lo_sw_en, hi_sw_en, lo_iso_n, hi_iso_n, ret_save;
  logic lo_out_a_iso, lo_out_b_iso, hi_out_iso;
  logic [2:0] cur_state;
  logic busy, req_err;

  int checks = 0;
  int errors = 0;
  int ncyc   = 0;

  logic [ACK_LAT-1:0] lo_sr, hi_sr;

  int t_lo_iso_fall, t_lo_iso_rise, t_ret_rise, t_ret_fall;
  int t_lo_sw_rise, t_lo_sw_fall, t_hi_sw_rise, t_hi_sw_fall, t_lo_ack_rise;
  int ret_toggles, err_pulses;
  logic p_lo_iso, p_ret, p_lo_sw, p_hi_sw, p_lo_ack;

  always #2 clk = ~clk;

  pwr_gate_seq #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_state(req_state),
    .save_cycles(CW'(SAVE)), .settle_cycles(CW'(SETTLE)), .restore_cycles(CW'(RESTORE)),
    .lo_ack(lo_ack), .hi_ack(hi_ack),
    .lo_out_a(lo_out_a), .lo_out_b(lo_out_b), .hi_out(hi_out),
    .lo_sw_en(lo_sw_en), .hi_sw_en(hi_sw_en), .lo_iso_n(lo_iso_n), .hi_iso_n(hi_iso_n),
    .ret_save(ret_save), .lo_out_a_iso(lo_out_a_iso), .lo_out_b_iso(lo_out_b_iso),
    .hi_out_iso(hi_out_iso), .cur_state(cur_state), .busy(busy), .req_err(req_err)
  );

  assign lo_ack = lo_sr[ACK_LAT-1];
  assign hi_ack = hi_sr[ACK_LAT-1];

  // switch model and event monitor, both on the falling edge
  always @(negedge clk) begin
    ncyc <= ncyc + 1;
    lo_sr <= {lo_sr[ACK_LAT-2:0], ~lo_sw_en};
    hi_sr <= {hi_sr[ACK_LAT-2:0], ~hi_sw_en};
    if (rst_n) begin
      if (p_lo_iso && !lo_iso_n) t_lo_iso_fall <= ncyc;
      if (!p_lo_iso && lo_iso_n) t_lo_iso_rise <= ncyc;
      if (!p_ret && ret_save)    t_ret_rise    <= ncyc;
      if (p_ret && !ret_save)    t_ret_fall    <= ncyc;
      if (p_ret != ret_save)     ret_toggles   <= ret_toggles + 1;
      if (!p_lo_sw && lo_sw_en)  t_lo_sw_rise  <= ncyc;
      if (p_lo_sw && !lo_sw_en)  t_lo_sw_fall  <= ncyc;
      if (!p_hi_sw && hi_sw_en)  t_hi_sw_rise  <= ncyc;
      if (p_hi_sw && !hi_sw_en)  t_hi_sw_fall  <= ncyc;
      if (!p_lo_ack && lo_ack)   t_lo_ack_rise <= ncyc;
      if (req_err)               err_pulses    <= err_pulses + 1;
    end
    p_lo_iso <= lo_iso_n;
    p_ret    <= ret_save;
    p_lo_sw  <= lo_sw_en;
    p_hi_sw  <= hi_sw_en;
    p_lo_ack <= lo_ack;
    if (ncyc > 20000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 20000", ncyc);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic request(input logic [2:0] code);
    @(negedge clk);
    req_valid = 1'b1;
    req_state = code;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(cur_state == 3'd0, "R1 state", cur_state, 0);
    chk(lo_sw_en && hi_sw_en, "R1 switch enables", {lo_sw_en, hi_sw_en}, 3);
    chk(!lo_iso_n && !hi_iso_n, "R1 isolation", {lo_iso_n, hi_iso_n}, 0);
    chk(!ret_save && !busy, "R1 retention/busy", {ret_save, busy}, 0);
  endtask

  task automatic t_clamp_off();
    lo_out_a = 1'b0; lo_out_b = 1'b1; hi_out = 1'b0;
    @(negedge clk);
    chk({lo_out_a_iso, lo_out_b_iso, hi_out_iso} == 3'b101, "R4 clamp values",
        {lo_out_a_iso, lo_out_b_iso, hi_out_iso}, 5);
  endtask

  task automatic t_lo_up_first();
    request(3'd2);
    @(negedge clk);
    request(3'd3); // R10 during busy
    wait_idle();
    chk(cur_state == 3'd2, "R10 ignored request / R3 state", cur_state, 2);
    chk(!lo_sw_en && hi_sw_en, "R3 switch polarity", {lo_sw_en, hi_sw_en}, 1);
    chk(t_lo_iso_rise - t_lo_ack_rise == SETTLE + RESTORE + 2, "R3 ack to release",
        t_lo_iso_rise - t_lo_ack_rise, SETTLE + RESTORE + 2);
    chk({lo_out_a_iso, lo_out_b_iso} == 2'b01, "R4 pass-through",
        {lo_out_a_iso, lo_out_b_iso}, 1);
  endtask

  task automatic t_same();
    int e0;
    e0 = err_pulses;
    request(3'd2);
    @(negedge clk);
    chk(!busy, "R11 no busy", busy, 0);
    @(negedge clk);
    chk(err_pulses == e0 && cur_state == 3'd2, "R11 no-op", err_pulses - e0, 0);
  endtask

  task automatic t_lo_down();
    request(3'd0);
    wait_idle();
    chk(t_ret_rise - t_lo_iso_fall == 1, "R5 iso then save", t_ret_rise - t_lo_iso_fall, 1);
    chk(t_lo_sw_rise - t_ret_rise == SAVE + 1, "R5 save wait", t_lo_sw_rise - t_ret_rise, SAVE + 1);
    chk(cur_state == 3'd0 && ret_save, "R5 off with save held", cur_state, 0);
  endtask

  task automatic t_illegal();
    int e0;
    e0 = err_pulses;
    request(3'd6);
    repeat (2) @(negedge clk);
    chk(err_pulses == e0 + 1, "R2 illegal code error", err_pulses - e0, 1);
    chk(cur_state == 3'd0 && !busy, "R2 no change", cur_state, 0);
  endtask

  task automatic t_hi_only();
    int r0;
    r0 = ret_toggles;
    request(3'd1);
    wait_idle();
    chk(cur_state == 3'd1 && !hi_sw_en && hi_iso_n, "R2 high-only state", cur_state, 1);
    chk(ret_toggles == r0, "R7 retention untouched", ret_toggles - r0, 0);
    hi_out = 1'b0;
    @(negedge clk);
    chk(!hi_out_iso, "R4 high pass-through", hi_out_iso, 0);
  endtask

  task automatic t_swap();
    request(3'd2);
    wait_idle();
    chk(cur_state == 3'd2, "R9 swap result", cur_state, 2);
    chk(t_hi_sw_rise < t_lo_sw_fall, "R9 down before up", t_hi_sw_rise, t_lo_sw_fall);
    chk(t_ret_fall - t_lo_sw_fall == ACK_LAT + SETTLE + 1, "R6 settle",
        t_ret_fall - t_lo_sw_fall, ACK_LAT + SETTLE + 1);
    chk(t_lo_iso_rise - t_ret_fall == RESTORE + 1, "R6 restore",
        t_lo_iso_rise - t_ret_fall, RESTORE + 1);
  endtask

  task automatic t_refuse();
    int e0;
    request(3'd3);
    wait_idle();
    chk(cur_state == 3'd3, "R2 both on", cur_state, 3);
    e0 = err_pulses;
    request(3'd2);
    repeat (3) @(negedge clk);
    chk(err_pulses == e0 + 1, "R8 refusal error", err_pulses - e0, 1);
    chk(cur_state == 3'd3 && !hi_sw_en, "R8 state kept", cur_state, 3);
  endtask

  task automatic t_split();
    request(3'd0);
    wait_idle();
    chk(cur_state == 3'd0, "R9 all off", cur_state, 0);
    chk(t_lo_sw_rise < t_hi_sw_rise, "R9 low down first", t_lo_sw_rise, t_hi_sw_rise);
    request(3'd3);
    wait_idle();
    chk(cur_state == 3'd3, "R9 all on", cur_state, 3);
    chk(t_lo_sw_fall < t_hi_sw_fall, "R9 low up first", t_lo_sw_fall, t_hi_sw_fall);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_state = 3'd0;
    lo_out_a = 1'b0; lo_out_b = 1'b1; hi_out = 1'b0;
    lo_sr = '0; hi_sr = '0;
    p_lo_iso = 1'b0; p_ret = 1'b0; p_lo_sw = 1'b1; p_hi_sw = 1'b1; p_lo_ack = 1'b0;
    t_lo_iso_fall = 0; t_lo_iso_rise = 0; t_ret_rise = 0; t_ret_fall = 0;
    t_lo_sw_rise = 0; t_lo_sw_fall = 0; t_hi_sw_rise = 0; t_hi_sw_fall = 0;
    t_lo_ack_rise = 0; ret_toggles = 0; err_pulses = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_clamp_off();
    t_lo_up_first();
    t_same();
    t_lo_down();
    t_illegal();
    t_hi_only();
    t_swap();
    t_refuse();
    t_split();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule